// File: doc/BRIEF.md
# Bus Monitor Message Filter and Capture Trigger

This block sits behind the word decoder of one serial command/response bus monitor and looks at every command word the decoder reports. For each one it answers two questions. The first is whether the message is worth recording. A table of enable bits answers it, indexed by the remote terminal address, the transmit/receive bit and the subaddress of the command. The second is whether the capture flag should go up, which is set by a selectable event. The event can be the first recorded message, a masked match against a reference command, a masked set of per-message exception flags, or a rising edge on one of several external trigger pins.

Software programs the table and the capture registers through a single write port. The capture flag is sticky: it stays set until a clear command is written. A system with several buses places one instance of the block per bus. Each instance keeps its own table and its own capture state.

Top module: `mon_filter_capture`

## Requirements
- R1: After reset every table entry is 0, capture is disabled, `cap_flag` is 0 and `mon_vld`/`mon_en` are 0.
- R2: A command on `cmd_vld` produces `mon_vld`=1 on the next cycle. In that cycle `mon_en` equals the table entry at index `cmd_word[15:5]`, which is {address[15:11], T/R[10], subaddress[9:5]}. The word count bits [4:0] play no part.
- R3: A write with `cfg_sel`=0 stores `cfg_wdata[0]` into the table entry `cfg_addr`. All 2048 entries, from index 0 to index 2047, can be reached.
- R4: A write with `cfg_sel`=1 sets the capture mode from `cfg_wdata[1:0]` (0 immediate, 1 template, 2 exception, 3 trigger), the trigger pin from `cfg_wdata[3:2]` and the enable bit from `cfg_wdata[4]`. While the enable bit is 0, no event sets the flag.
- R5: In immediate mode, the first command that passes the filter sets `cap_flag`, visible in the same cycle as its `mon_vld`.
- R6: In template mode, a filtered command sets the flag when `((cmd_word ^ ref) & mask) == 0`. The reference is written with `cfg_sel`=2 and the mask with `cfg_sel`=3.
- R7: In exception mode, an `exc_vld` pulse sets the flag on the next cycle if `exc_flags & excmask` is nonzero and the latest command passed the filter. The mask is written with `cfg_sel`=4. The flag bits are: 0 invalid command, 1 invalid data, 2 invalid status, 3 gap before data, 4 response time, 5 wrong address, 6 status set, 7 illegal command.
- R8: In trigger mode, only a rising edge on the selected pin sets the flag, after passing through a two-stage synchronizer. Other pins have no effect, and a pin held high does not fire again.
- R9: `cap_flag` stays set until a write with `cfg_sel`=5. That write clears the flag on the next cycle and takes priority over an event in the same cycle.
- R10: A command that fails the filter never sets the flag in immediate or template mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Command word strobe |
| cmd_word | input | 16 | Decoded command word |
| exc_vld | input | 1 | Exception flags strobe for the current message |
| exc_flags | input | 8 | Per-message exception flags |
| trig_pin | input | 4 | Asynchronous external trigger pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 table, 1 mode, 2 reference, 3 mask, 4 exception mask, 5 clear flag |
| cfg_addr | input | 11 | Table index for table writes |
| cfg_wdata | input | 16 | Write data |
| mon_vld | output | 1 | Filter decision valid |
| mon_en | output | 1 | Message is to be recorded |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The bench builds the block with its default parameters: 5-bit address and subaddress fields, a 16-bit word, 8 exception classes and 4 trigger pins. With these values both ends of the 2048-entry table can be written and read back through the filter decision. The two exception classes used in the test sit at distinct bit positions, so a masked class can be told apart from an unmasked one. Trigger pin 2 can be selected while pin 1 toggles, which shows that the trigger selection is honoured.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    CAP_IMM  = 2'd0,
    CAP_TMPL = 2'd1,
    CAP_EXC  = 2'd2,
    CAP_TRIG = 2'd3
  } cap_mode_e;

  typedef enum logic [2:0] {
    SEL_TABLE = 3'd0,
    SEL_MODE  = 3'd1,
    SEL_REF   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_EXCM  = 3'd4,
    SEL_CLEAR = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/mfc_lookup.sv
module mfc_lookup #(
  parameter int IDX_W = 11,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             rd_vld,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hit,
  output logic             mon_vld,
  output logic             mon_en,
  output logic             msg_hit
);
  logic [DEPTH-1:0] tbl_q;

  assign rd_hit = tbl_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_vld <= 1'b0;
      mon_en  <= 1'b0;
      msg_hit <= 1'b0;
    end else begin
      mon_vld <= rd_vld;
      mon_en  <= rd_vld & rd_hit;
      if (rd_vld) msg_hit <= rd_hit;
    end
  end

  AST_EN_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> mon_vld); // R2
  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_bit)); // R3
endmodule

// File: rtl/mfc_trig_edge.sv
module mfc_trig_edge #(
  parameter int TRIG_N = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_N-1:0] pins,
  input  logic [SEL_W-1:0]  sel,
  output logic              evt
);
  logic [TRIG_N-1:0] s1_q, s2_q, prev_q;
  logic [TRIG_N-1:0] rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pins;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_w = s2_q & ~prev_q;
  assign evt    = rise_w[sel];

  AST_TRIG_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (sel != $past(sel)) || !evt); // R8
endmodule

// File: rtl/mfc_capture.sv
module mfc_capture
  import mfc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXC_W  = 8,
  parameter int SEL_W  = 2,
  localparam int EN_BIT = 2 + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cmd_vld,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_hit,
  input  logic              exc_vld,
  input  logic [EXC_W-1:0]  exc_flags,
  input  logic              msg_hit,
  input  logic              trig_evt,
  output logic [SEL_W-1:0]  trig_sel,
  output logic              cap_flag
);
  cap_mode_e         mode_q;
  logic              en_q;
  logic [WORD_W-1:0] ref_q, mask_q;
  logic [EXC_W-1:0]  excm_q;

  logic clr_w, imm_evt, tmpl_evt, exc_evt, trg_evt, any_evt;

  function automatic logic tmpl_match(input logic [WORD_W-1:0] w,
                                      input logic [WORD_W-1:0] r,
                                      input logic [WORD_W-1:0] m);
    return ((w ^ r) & m) == '0;
  endfunction

  function automatic logic exc_match(input logic [EXC_W-1:0] f,
                                     input logic [EXC_W-1:0] m);
    return |(f & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= CAP_IMM;
      trig_sel <= '0;
      en_q     <= 1'b0;
      ref_q    <= '0;
      mask_q   <= '0;
      excm_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_MODE: begin
          mode_q   <= cap_mode_e'(cfg_wdata[1:0]);
          trig_sel <= cfg_wdata[2 +: SEL_W];
          en_q     <= cfg_wdata[EN_BIT];
        end
        SEL_REF:  ref_q  <= cfg_wdata;
        SEL_MASK: mask_q <= cfg_wdata;
        SEL_EXCM: excm_q <= cfg_wdata[EXC_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_w    = cfg_we && (cfg_sel == SEL_CLEAR);
  assign imm_evt  = (mode_q == CAP_IMM)  && cmd_vld && cmd_hit;
  assign tmpl_evt = (mode_q == CAP_TMPL) && cmd_vld && cmd_hit &&
                    tmpl_match(cmd_word, ref_q, mask_q);
  assign exc_evt  = (mode_q == CAP_EXC)  && exc_vld && msg_hit &&
                    exc_match(exc_flags, excm_q);
  assign trg_evt  = (mode_q == CAP_TRIG) && trig_evt;
  assign any_evt  = en_q && (imm_evt || tmpl_evt || exc_evt || trg_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_flag <= 1'b0;
    else if (clr_w)   cap_flag <= 1'b0;
    else if (any_evt) cap_flag <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !clr_w |=> cap_flag); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !cap_flag); // R9
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(en_q)); // R4
  AST_IMM_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) && $past(mode_q == CAP_IMM) |-> $past(cmd_vld && cmd_hit)); // R10
endmodule

// File: rtl/mon_filter_capture.sv
module mon_filter_capture
  import mfc_pkg::*;
#(
  parameter int RT_W   = 5,
  parameter int SA_W   = 5,
  parameter int WORD_W = 16,
  parameter int EXC_W  = 8,
  parameter int TRIG_N = 4,
  localparam int IDX_W = RT_W + 1 + SA_W,
  localparam int SEL_W = $clog2(TRIG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              exc_vld,
  input  logic [EXC_W-1:0]  exc_flags,
  input  logic [TRIG_N-1:0] trig_pin,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              mon_vld,
  output logic              mon_en,
  output logic              cap_flag
);
  function automatic logic [IDX_W-1:0] cmd_index(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: IDX_W];
  endfunction

  logic             tbl_we;
  logic [IDX_W-1:0] rd_idx;
  logic             cmd_hit, msg_hit, trig_evt;
  logic [SEL_W-1:0] trig_sel;

  assign tbl_we = cfg_we && (cfg_sel == SEL_TABLE);
  assign rd_idx = cmd_index(cmd_word);

  mfc_lookup #(.IDX_W(IDX_W)) lookup_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(cfg_addr), .wr_bit(cfg_wdata[0]),
    .rd_vld(cmd_vld), .rd_idx(rd_idx), .rd_hit(cmd_hit),
    .mon_vld(mon_vld), .mon_en(mon_en), .msg_hit(msg_hit)
  );

  mfc_trig_edge #(.TRIG_N(TRIG_N), .SEL_W(SEL_W)) trig_i (
    .clk(clk), .rst_n(rst_n), .pins(trig_pin), .sel(trig_sel), .evt(trig_evt)
  );

  mfc_capture #(.WORD_W(WORD_W), .EXC_W(EXC_W), .SEL_W(SEL_W)) cap_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_vld(cmd_vld), .cmd_word(cmd_word), .cmd_hit(cmd_hit),
    .exc_vld(exc_vld), .exc_flags(exc_flags), .msg_hit(msg_hit),
    .trig_evt(trig_evt), .trig_sel(trig_sel), .cap_flag(cap_flag)
  );

  AST_MON_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> mon_vld); // R2
endmodule

// File: tb/mon_filter_capture_tb_top.sv
`timescale 1ns/1ps
module mon_filter_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        exc_vld = 1'b0;
  logic [7:0]  exc_flags = '0;
  logic [3:0]  trig_pin = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [10:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        mon_vld, mon_en, cap_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Word layout: address [15:11], T/R [10], subaddress [9:5], count [4:0]
  localparam logic [15:0] W_HIT   = 16'h1CE4; // index 231, count 4
  localparam logic [15:0] W_HIT9  = 16'h1CE9; // index 231, count 9
  localparam logic [15:0] W_TRFLIP = 16'h18E4; // index 199, T/R differs
  localparam logic [15:0] W_ZERO  = 16'h0004; // index 0
  localparam logic [15:0] W_TOP   = 16'hFFE0; // index 2047

  mon_filter_capture dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
    .exc_vld(exc_vld), .exc_flags(exc_flags), .trig_pin(trig_pin),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mon_vld(mon_vld), .mon_en(mon_en),
    .cap_flag(cap_flag)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [10:0] addr, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Leaves the bench at the negedge where the decision is visible
  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic send_exc(input logic [7:0] f);
    @(negedge clk);
    exc_vld = 1'b1; exc_flags = f;
    @(negedge clk);
    exc_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 cap_flag after reset", cap_flag, 0);
    check("R1 mon_vld after reset", mon_vld, 0);
    send_cmd(W_TOP);
    check("R1 mon_vld follows cmd", mon_vld, 1);
    check("R1 table cleared (2047)", mon_en, 0);
    send_cmd(W_ZERO);
    check("R1 table cleared (0)", mon_en, 0);
  endtask

  task automatic t_lookup;
    cfg_write(3'd0, 11'd231, 16'h0001);
    cfg_write(3'd0, 11'd0, 16'h0001);
    cfg_write(3'd0, 11'd2047, 16'h0001);
    send_cmd(W_HIT);
    check("R2 hit on enabled entry", mon_en, 1);
    send_cmd(W_HIT9);
    check("R2 word count ignored", mon_en, 1);
    send_cmd(W_TRFLIP);
    check("R2 T/R bit selects entry", mon_en, 0);
    send_cmd(W_ZERO);
    check("R3 index 0 reachable", mon_en, 1);
    send_cmd(W_TOP);
    check("R3 index 2047 reachable", mon_en, 1);
    cfg_write(3'd0, 11'd2047, 16'h0000);
    send_cmd(W_TOP);
    check("R3 entry cleared by write", mon_en, 0);
    @(negedge clk);
    check("R2 mon_vld single cycle", mon_vld, 0);
  endtask

  task automatic t_disabled;
    cfg_write(3'd1, 11'd0, 16'h0000); // immediate, enable off
    send_cmd(W_HIT);
    check("R4 no capture while disabled", cap_flag, 0);
  endtask

  task automatic t_immediate;
    cfg_write(3'd1, 11'd0, 16'h0010);
    send_cmd(W_TRFLIP);
    check("R10 unfiltered cmd ignored (imm)", cap_flag, 0);
    send_cmd(W_HIT);
    check("R5 immediate sets flag", cap_flag, 1);
    idle(10);
    check("R9 flag sticky", cap_flag, 1);
    cfg_write(3'd5, 11'd0, 16'h0000);
    check("R9 clear write", cap_flag, 0);
  endtask

  task automatic t_clear_race;
    send_cmd(W_HIT);
    check("R5 immediate re-arms after clear", cap_flag, 1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cmd_vld = 1'b1; cmd_word = W_HIT;
    @(negedge clk);
    cfg_we = 1'b0; cmd_vld = 1'b0;
    check("R9 clear wins over event", cap_flag, 0);
  endtask

  task automatic t_template;
    cfg_write(3'd2, 11'd0, W_HIT);
    cfg_write(3'd3, 11'd0, 16'hFFE0);
    cfg_write(3'd1, 11'd0, 16'h0011);
    send_cmd(W_ZERO);
    check("R6 filtered mismatch", cap_flag, 0);
    send_cmd(W_HIT9);
    check("R6 masked match", cap_flag, 1);
    cfg_write(3'd5, 11'd0, 16'h0000);
    cfg_write(3'd3, 11'd0, 16'hFFFF);
    send_cmd(W_HIT9);
    check("R6 full mask mismatch", cap_flag, 0);
    cfg_write(3'd2, 11'd0, W_TRFLIP);
    send_cmd(W_TRFLIP);
    check("R10 unfiltered match ignored (tmpl)", cap_flag, 0);
  endtask

  task automatic t_exception;
    cfg_write(3'd4, 11'd0, 16'h0020); // wrong address class only
    cfg_write(3'd1, 11'd0, 16'h0012);
    send_cmd(W_HIT);
    send_exc(8'h10);
    check("R7 unmasked class ignored", cap_flag, 0);
    send_exc(8'h20);
    check("R7 masked class sets flag", cap_flag, 1);
    cfg_write(3'd5, 11'd0, 16'h0000);
    send_cmd(W_TRFLIP);
    send_exc(8'h20);
    check("R7 unfiltered message ignored", cap_flag, 0);
  endtask

  task automatic t_trigger;
    cfg_write(3'd1, 11'd0, 16'h001B); // trigger, pin 2, enabled
    @(negedge clk); trig_pin[1] = 1'b1;
    idle(6);
    check("R8 unselected pin ignored", cap_flag, 0);
    trig_pin[1] = 1'b0;
    trig_pin[2] = 1'b1;
    idle(6);
    check("R8 selected pin edge", cap_flag, 1);
    cfg_write(3'd5, 11'd0, 16'h0000);
    idle(6);
    check("R8 held level no refire", cap_flag, 0);
    trig_pin[2] = 1'b0;
    idle(4);
    trig_pin[2] = 1'b1;
    idle(6);
    check("R8 new edge fires", cap_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lookup();
    t_disabled();
    t_immediate();
    t_clear_race();
    t_template();
    t_exception();
    t_trigger();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule